// File: doc/BRIEF.md
# EEPROM Software Write-Protect Unit

This unit sits behind the bit-level front end of a serial EEPROM slave. It keeps two protection flags. The permanent flag can only ever be set. The reversible flag can be set and cleared. Protection commands are told apart from ordinary memory traffic by their own 4-bit address prefix. The unit receives decoded bus events from the front end: START and STOP pulses, a header byte once it has been received, a pulse for each later byte, the level of a high-voltage detector on address strap A0, and the hardware protect pin. For every phase of a protection command it answers with an ACK or NACK decision. Flag updates are applied at STOP.

A flag is queried through the acknowledge bit alone. No data byte is returned. A reversible-flag command is honoured only when the high-voltage condition on A0 was already present at START and stays present through STOP. If that condition is missing, the command is handled as a permanent-flag command.

The unit also decides, for each memory write address, whether the write may proceed. When either flag is set, the lower half of the array is locked. When the hardware protect pin is high, the whole array is locked.

Top module: `eeprom_wprot_unit`

## Requirements
- R1: After reset both flags are clear. A query of either flag answers ACK, and with `wp_pin` low every memory address is reported writable.
- R2: Only header bytes whose upper nibble (bits 7:4) is 0110 get a response. Any other prefix produces no `ack_vld`. A response appears exactly one cycle after the `hdr_vld` or `byte_vld` pulse it answers.
- R3: A header with R/W (bit 0) = 1 is a flag query. It answers NACK if the addressed flag is set and ACK if it is clear. A query changes no flag and starts no write cycle.
- R4: A set or clear command (R/W = 0) is acknowledged on its header, on a dummy address byte and on a dummy data byte. At the following STOP the flag changes and `wc_start` pulses, both visible one cycle after the `bus_stop` pulse.
- R5: While either flag is set, addresses with MSB 0 (00h–7Fh) report `mem_wr_ok` = 0 and addresses with MSB 1 (80h–FFh) report 1.
- R6: With `wp_pin` high, `mem_wr_ok` is 0 for every address. The data byte of a flag command is then NACKed, and the following STOP changes no flag and gives no `wc_start`.
- R7: A reversible command needs the high-voltage level on A0 from START on and header bits A2 (bit 3) = 0 and A0 (bit 1) = 1. Header bit A1 (bit 2) = 0 selects set and A1 = 1 selects clear. A clear removes the lower-half lock.
- R8: A write command issued without high voltage at START sets the permanent flag, whatever its three address bits are. A reversible command whose high-voltage level drops before STOP also sets the permanent flag.
- R9: Once the permanent flag is set it never clears. Every set or clear header is then NACKed, while queries are still answered.
- R10: While the reversible flag is set, a reversible set header is NACKed and a reversible clear header is ACKed.
- R11: While `wc_busy` is high, every protection header is NACKed.
- R12: A STOP that arrives without an acknowledged data byte, or a command abandoned by a repeated START, changes no flag and gives no `wc_start`.
- R13: A header received with high voltage present at START but without the reversible pattern (A2 = 0, A0 = 1) is NACKed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_start | input | 1 | Pulse: START or repeated START seen |
| bus_stop | input | 1 | Pulse: STOP seen |
| hdr_vld | input | 1 | Pulse: header byte received |
| hdr_byte | input | 8 | Header: prefix[7:4], A2[3], A1[2], A0[1], R/W[0] |
| byte_vld | input | 1 | Pulse: byte after the header received |
| hv_a0 | input | 1 | High-voltage detector level on strap A0 |
| wp_pin | input | 1 | Hardware protect pin |
| wc_busy | input | 1 | Internal write cycle in progress |
| mem_wr_addr | input | ADDR_W | Memory write address to be judged |
| ack_vld | output | 1 | A phase decision is presented |
| ack_ok | output | 1 | 1 = ACK, 0 = NACK |
| wc_start | output | 1 | Pulse: start a write-cycle busy period |
| mem_wr_ok | output | 1 | Write to `mem_wr_addr` permitted |

## Verification
The bench builds the unit with its defaults: an 8-bit memory address and protection prefix 0110. With these values the 7Fh/80h boundary of the lower-half lock is reachable, and so are both ends of the array. Any header bit pattern can be driven, so both the memory prefix and the protection prefix are exercised, along with every reversible set/clear and query encoding. A reset in the middle of the run lets the bench cover the sticky permanent flag and the lost high-voltage path, each starting from clear flags.

// File: rtl/eeprom_wprot_pkg.sv
// Shared types for the EEPROM write-protect unit.
// Assumes: one pending protection command at a time.
package eeprom_wprot_pkg;
    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_SET_P,
        CMD_SET_R,
        CMD_CLR_R
    } cmd_e;

    typedef enum logic [1:0] {
        PH_ADDR,
        PH_DATA,
        PH_DONE
    } phase_e;
endpackage

// File: rtl/wprot_hv_qual.sv
// Tracks whether the A0 high-voltage level has been present without a
// break since the last START.
// Assumes: hv_a0 is already synchronised and filtered by the front end.
module wprot_hv_qual (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_start,
    input  logic hv_a0,
    output logic hv_qual
);
    logic hold_q;

    // Load the level at START, then drop it for good on any gap.
    always_ff @(posedge clk) begin
        if (!rst_n)         hold_q <= 1'b0;
        else if (bus_start) hold_q <= hv_a0;
        else                hold_q <= hold_q & hv_a0;
    end

    assign hv_qual = hold_q & hv_a0;
endmodule

// File: rtl/wprot_flags.sv
// Holds the permanent and reversible protection flags.
// Assumes: set_r and clr_r never pulse together.
module wprot_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic set_p,
    input  logic set_r,
    input  logic clr_r,
    output logic pswp,
    output logic rswp
);
    logic pswp_q, rswp_q;

    // Permanent flag: set only, never cleared except by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     pswp_q <= 1'b0;
        else if (set_p) pswp_q <= 1'b1;
    end

    // Reversible flag: separate set and clear requests.
    always_ff @(posedge clk) begin
        if (!rst_n)     rswp_q <= 1'b0;
        else if (set_r) rswp_q <= 1'b1;
        else if (clr_r) rswp_q <= 1'b0;
    end

    assign pswp = pswp_q;
    assign rswp = rswp_q;

    p_perm_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pswp_q |=> pswp_q);

    p_flags_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_p || set_r || clr_r) |=> $stable({pswp_q, rswp_q}));
endmodule

// File: rtl/wprot_cmd_ctl.sv
// Decodes protection headers, produces the ACK/NACK decision per phase,
// and issues flag updates and a write-cycle start at STOP.
// Assumes: header layout prefix[7:4], A2[3], A1[2], A0[1], R/W[0];
// the front end pulses at most one of start/stop/hdr/byte per cycle.
module wprot_cmd_ctl
    import eeprom_wprot_pkg::*;
#(
    parameter logic [3:0] PROT_PREFIX = 4'b0110
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_start,
    input  logic       bus_stop,
    input  logic       hdr_vld,
    input  logic [7:0] hdr_byte,
    input  logic       byte_vld,
    input  logic       hv_qual,
    input  logic       wp_pin,
    input  logic       wc_busy,
    input  logic       pswp,
    input  logic       rswp,
    output logic       ack_vld,
    output logic       ack_ok,
    output logic       wc_start,
    output logic       set_p,
    output logic       set_r,
    output logic       clr_r
);
    cmd_e   cmd_q,   hdr_cmd;
    phase_e phase_q;
    logic   armed_q, ack_vld_q, ack_ok_q, wc_start_q;
    logic   hdr_ours, hdr_ack, rv_pat, commit;
    logic   h_a2, h_a1, h_a0, h_rw;

    assign hdr_ours = (hdr_byte[7:4] == PROT_PREFIX);
    assign h_a2     = hdr_byte[3];
    assign h_a1     = hdr_byte[2];
    assign h_a0     = hdr_byte[1];
    assign h_rw     = hdr_byte[0];
    assign rv_pat   = hv_qual && !h_a2 && h_a0;

    // Header decision: which command it is and whether it is accepted.
    always_comb begin
        hdr_ack = 1'b0;
        hdr_cmd = CMD_NONE;
        if (wc_busy) begin
            hdr_ack = 1'b0;
        end else if (h_rw) begin
            if (rv_pat)       hdr_ack = !rswp;
            else if (hv_qual) hdr_ack = 1'b0;
            else              hdr_ack = !pswp;
        end else if (rv_pat) begin
            if (!h_a1) begin
                hdr_ack = !pswp && !rswp;
                hdr_cmd = CMD_SET_R;
            end else begin
                hdr_ack = !pswp;
                hdr_cmd = CMD_CLR_R;
            end
        end else if (!hv_qual) begin
            hdr_ack = !pswp;
            hdr_cmd = CMD_SET_P;
        end
        if (!hdr_ack) hdr_cmd = CMD_NONE;
    end

    // Commit decision at STOP; a lost qualifier falls back to the permanent flag.
    assign commit = bus_stop && armed_q && !bus_start;
    assign set_r  = commit && (cmd_q == CMD_SET_R) && hv_qual;
    assign clr_r  = commit && (cmd_q == CMD_CLR_R) && hv_qual;
    assign set_p  = commit && ((cmd_q == CMD_SET_P) ||
                    (((cmd_q == CMD_SET_R) || (cmd_q == CMD_CLR_R)) && !hv_qual));

    // Phase sequencing and registered acknowledge decision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q      <= CMD_NONE;
            phase_q    <= PH_ADDR;
            armed_q    <= 1'b0;
            ack_vld_q  <= 1'b0;
            ack_ok_q   <= 1'b0;
            wc_start_q <= 1'b0;
        end else begin
            ack_vld_q  <= 1'b0;
            ack_ok_q   <= 1'b0;
            wc_start_q <= commit;
            if (bus_start || bus_stop) begin
                cmd_q   <= CMD_NONE;
                armed_q <= 1'b0;
            end else if (hdr_vld) begin
                cmd_q   <= hdr_ours ? hdr_cmd : CMD_NONE;
                phase_q <= PH_ADDR;
                armed_q <= 1'b0;
                if (hdr_ours) begin
                    ack_vld_q <= 1'b1;
                    ack_ok_q  <= hdr_ack;
                end
            end else if (byte_vld && cmd_q != CMD_NONE) begin
                ack_vld_q <= 1'b1;
                case (phase_q)
                    PH_ADDR: begin
                        ack_ok_q <= 1'b1;
                        phase_q  <= PH_DATA;
                    end
                    PH_DATA: begin
                        ack_ok_q <= !wp_pin;
                        armed_q  <= !wp_pin;
                        phase_q  <= PH_DONE;
                    end
                    default: ack_ok_q <= 1'b0;
                endcase
            end
        end
    end

    assign ack_vld  = ack_vld_q;
    assign ack_ok   = ack_ok_q;
    assign wc_start = wc_start_q;

    p_ack_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(hdr_vld || byte_vld) |=> !ack_vld_q);

    p_wc_after_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_stop |=> !wc_start_q);

    p_wp_data_nack_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_vld && !hdr_vld && !bus_start && !bus_stop && cmd_q != CMD_NONE
         && phase_q == PH_DATA && wp_pin) |=> (ack_vld_q && !ack_ok_q));

    p_locked_nack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_vld && hdr_ours && !h_rw && pswp && !bus_start && !bus_stop)
        |=> (ack_vld_q && !ack_ok_q));

    p_busy_nack_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (hdr_vld && hdr_ours && wc_busy && !bus_start && !bus_stop)
        |=> (ack_vld_q && !ack_ok_q));
endmodule

// File: rtl/wprot_wr_gate.sv
// Judges whether a memory write address may be written.
// Assumes: the lower half is the range with address MSB 0.
module wprot_wr_gate #(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] mem_wr_addr,
    input  logic              wp_pin,
    input  logic              pswp,
    input  logic              rswp,
    output logic              mem_wr_ok
);
    localparam int HALF_BIT = ADDR_W - 1;

    logic in_low_half;

    // Hardware pin locks everything; either flag locks the lower half.
    always_comb begin
        in_low_half = !mem_wr_addr[HALF_BIT];
        mem_wr_ok   = !wp_pin && !((pswp || rswp) && in_low_half);
    end
endmodule

// File: rtl/eeprom_wprot_unit.sv
// Top of the EEPROM software write-protect unit: qualifier tracking,
// command control, flag storage and the memory write gate.
// Assumes: decoded, single-cycle bus event pulses from the front end.
module eeprom_wprot_unit #(
    parameter int         ADDR_W      = 8,
    parameter logic [3:0] PROT_PREFIX = 4'b0110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_start,
    input  logic              bus_stop,
    input  logic              hdr_vld,
    input  logic [7:0]        hdr_byte,
    input  logic              byte_vld,
    input  logic              hv_a0,
    input  logic              wp_pin,
    input  logic              wc_busy,
    input  logic [ADDR_W-1:0] mem_wr_addr,
    output logic              ack_vld,
    output logic              ack_ok,
    output logic              wc_start,
    output logic              mem_wr_ok
);
    logic hv_qual, pswp, rswp, set_p, set_r, clr_r;

    wprot_hv_qual u_hv (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start),
        .hv_a0(hv_a0), .hv_qual(hv_qual)
    );

    wprot_cmd_ctl #(.PROT_PREFIX(PROT_PREFIX)) u_ctl (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
        .hdr_vld(hdr_vld), .hdr_byte(hdr_byte), .byte_vld(byte_vld),
        .hv_qual(hv_qual), .wp_pin(wp_pin), .wc_busy(wc_busy),
        .pswp(pswp), .rswp(rswp), .ack_vld(ack_vld), .ack_ok(ack_ok),
        .wc_start(wc_start), .set_p(set_p), .set_r(set_r), .clr_r(clr_r)
    );

    wprot_flags u_flags (
        .clk(clk), .rst_n(rst_n), .set_p(set_p), .set_r(set_r),
        .clr_r(clr_r), .pswp(pswp), .rswp(rswp)
    );

    wprot_wr_gate #(.ADDR_W(ADDR_W)) u_gate (
        .mem_wr_addr(mem_wr_addr), .wp_pin(wp_pin), .pswp(pswp),
        .rswp(rswp), .mem_wr_ok(mem_wr_ok)
    );
endmodule

// File: tb/eeprom_wprot_unit_tb.sv
module eeprom_wprot_unit_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_start = 1'b0, bus_stop = 1'b0, hdr_vld = 1'b0, byte_vld = 1'b0;
    logic [7:0] hdr_byte = 8'h00;
    logic       hv_a0 = 1'b0, wp_pin = 1'b0, wc_busy = 1'b0;
    logic [7:0] mem_wr_addr = 8'h00;
    logic       ack_vld, ack_ok, wc_start, mem_wr_ok;

    int    n_chk = 0, n_fail = 0, cyc = 0;
    bit    exp_q[$];
    string tag_q[$];

    eeprom_wprot_unit #(.ADDR_W(8), .PROT_PREFIX(4'b0110)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_stop(bus_stop),
        .hdr_vld(hdr_vld), .hdr_byte(hdr_byte), .byte_vld(byte_vld),
        .hv_a0(hv_a0), .wp_pin(wp_pin), .wc_busy(wc_busy),
        .mem_wr_addr(mem_wr_addr), .ack_vld(ack_vld), .ack_ok(ack_ok),
        .wc_start(wc_start), .mem_wr_ok(mem_wr_ok)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Monitor: pops one expected decision per presented acknowledge.
    always @(negedge clk) begin
        if (rst_n && ack_vld) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2", "unexpected ack_vld", 1, 0);
            end else begin
                automatic bit    e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(ack_ok == e, t, "ack_ok", ack_ok, e);
            end
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 20000) begin
            check(1'b0, "R1", "watchdog expired", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
    endtask

    task automatic start(input bit hv);
        hv_a0 = hv;
        tick();
        bus_start = 1'b1;
        tick();
        bus_start = 1'b0;
        tick();
    endtask

    // Driver: resp 0 = no response expected, 1 = ACK, 2 = NACK.
    task automatic hdr(input logic [7:0] b, input int resp, input string tag);
        if (resp != 0) begin
            exp_q.push_back(resp == 1);
            tag_q.push_back(tag);
        end
        hdr_byte = b;
        hdr_vld  = 1'b1;
        tick();
        hdr_vld  = 1'b0;
        tick();
        tick();
    endtask

    task automatic dbyte(input int resp, input string tag);
        if (resp != 0) begin
            exp_q.push_back(resp == 1);
            tag_q.push_back(tag);
        end
        byte_vld = 1'b1;
        tick();
        byte_vld = 1'b0;
        tick();
        tick();
    endtask

    task automatic stop(input bit exp_wc, input string tag);
        bus_stop = 1'b1;
        tick();
        bus_stop = 1'b0;
        check(wc_start == exp_wc, tag, "wc_start", wc_start, exp_wc);
        tick();
        hv_a0 = 1'b0;
    endtask

    task automatic gate(input logic [7:0] a, input bit exp, input string tag);
        mem_wr_addr = a;
        #1;
        check(mem_wr_ok == exp, tag, $sformatf("mem_wr_ok @%02h", a), mem_wr_ok, exp);
    endtask

    // Header encodings: prefix 0110, A2 A1 A0, R/W.
    localparam logic [7:0] RD_P  = 8'b0110_000_1;
    localparam logic [7:0] RD_R  = 8'b0110_001_1;
    localparam logic [7:0] SET_R = 8'b0110_001_0;
    localparam logic [7:0] CLR_R = 8'b0110_011_0;

    initial begin
        do_reset();
        // R1: reset state
        gate(8'h00, 1'b1, "R1"); gate(8'hFF, 1'b1, "R1");
        start(1'b0); hdr(RD_P, 1, "R1"); stop(1'b0, "R3");
        start(1'b1); hdr(RD_R, 1, "R1"); stop(1'b0, "R3");
        // R2: memory prefix is ignored
        start(1'b0); hdr(8'b1010_000_0, 0, "R2"); dbyte(0, "R2"); dbyte(0, "R2"); stop(1'b0, "R2");
        // R7 / R4: set reversible flag
        start(1'b1); hdr(SET_R, 1, "R7"); dbyte(1, "R4"); dbyte(1, "R4"); stop(1'b1, "R4");
        gate(8'h7F, 1'b0, "R5"); gate(8'h80, 1'b1, "R5"); gate(8'h10, 1'b0, "R5");
        start(1'b1); hdr(RD_R, 2, "R3"); stop(1'b0, "R3");
        start(1'b0); hdr(RD_P, 1, "R3"); stop(1'b0, "R3");
        // R10: second set refused
        start(1'b1); hdr(SET_R, 2, "R10"); dbyte(0, "R10"); stop(1'b0, "R10");
        // R11: busy
        wc_busy = 1'b1;
        start(1'b0); hdr(RD_P, 2, "R11"); stop(1'b0, "R11");
        wc_busy = 1'b0;
        // R7 / R10: clear reversible flag
        start(1'b1); hdr(CLR_R, 1, "R10"); dbyte(1, "R7"); dbyte(1, "R7"); stop(1'b1, "R7");
        gate(8'h10, 1'b1, "R7");
        // R6: hardware protect
        wp_pin = 1'b1;
        gate(8'h90, 1'b0, "R6"); gate(8'h05, 1'b0, "R6");
        start(1'b0); hdr(8'b0110_101_0, 1, "R6"); dbyte(1, "R6"); dbyte(2, "R6"); stop(1'b0, "R6");
        wp_pin = 1'b0;
        start(1'b0); hdr(RD_P, 1, "R6"); stop(1'b0, "R6");
        // R12: stop before data, and repeated START abandon
        start(1'b1); hdr(SET_R, 1, "R12"); dbyte(1, "R12"); stop(1'b0, "R12");
        start(1'b1); hdr(SET_R, 1, "R12"); dbyte(1, "R12"); dbyte(1, "R12");
        start(1'b1); stop(1'b0, "R12");
        start(1'b1); hdr(RD_R, 1, "R12"); stop(1'b0, "R12");
        // R13: high voltage with wrong pattern
        start(1'b1); hdr(8'b0110_100_1, 2, "R13"); stop(1'b0, "R13");
        start(1'b1); hdr(8'b0110_110_0, 2, "R13"); dbyte(0, "R13"); stop(1'b0, "R13");
        // R8: lost qualifier turns into permanent set
        start(1'b1); hdr(SET_R, 1, "R8"); dbyte(1, "R8"); dbyte(1, "R8");
        hv_a0 = 1'b0; tick();
        stop(1'b1, "R8");
        start(1'b0); hdr(RD_P, 2, "R8"); stop(1'b0, "R8");
        start(1'b1); hdr(RD_R, 1, "R8"); stop(1'b0, "R8");
        gate(8'h00, 1'b0, "R5");
        // R9: permanent lock
        start(1'b1); hdr(CLR_R, 2, "R9"); dbyte(0, "R9"); stop(1'b0, "R9");
        start(1'b0); hdr(8'b0110_111_0, 2, "R9"); stop(1'b0, "R9");
        start(1'b1); hdr(SET_R, 2, "R9"); stop(1'b0, "R9");
        start(1'b0); hdr(RD_P, 2, "R9"); stop(1'b0, "R9");
        // R8: permanent set with arbitrary address bits, from clear flags
        do_reset();
        start(1'b0); hdr(RD_P, 1, "R1"); stop(1'b0, "R1");
        start(1'b0); hdr(8'b0110_110_0, 1, "R8"); dbyte(1, "R8"); dbyte(1, "R8"); stop(1'b1, "R8");
        start(1'b0); hdr(RD_P, 2, "R8"); stop(1'b0, "R8");
        gate(8'h7F, 1'b0, "R5"); gate(8'hFF, 1'b1, "R5");
        repeat (4) tick();
        check(exp_q.size() == 0, "R2", "missing responses", exp_q.size(), 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule